// File: doc/BRIEF.md
# Batch Reactor Sequencing Controller

This block sequences one batch of a two-substrate reactor that discharges into a transport wagon. It reads ten sensor and operator inputs and drives nine actuators. The actuators are two feed pumps, two scale discharge valves, the reactor drain, the agitator, two wagon motion commands and the wagon tipping valve. One batch runs from an idle wait through these stages:

1. Preparation: both scales fill while the wagon travels left.
2. Reaction.
3. Dispensing: both scales discharge into the reactor while the agitator is regulated.
4. Draining of the reactor into the wagon.
5. Wagon travel to the right and tipping, then back to idle.

The stages with parallel activity are concurrent regions. They are flattened into one global state: a phase register plus one small register per sub-region. A concurrent phase is left only after every one of its sub-regions has reached its final substate. Every internally produced event is registered and is only seen by transitions on the following clock. This covers region completion, the one-tick reaction step and the wagon's "ready" event during draining. Outputs are decoded from the registered state alone. Inputs are assumed to be synchronous and clean.

Phases and their transitions:

| Phase | Leaves to | When |
|---|---|---|
| `PH_IDLE` | `PH_PREP` | start |
| `PH_PREP` | `PH_REACT` | all three preparation regions finished |
| `PH_REACT` | `PH_DISP` | unconditionally, after one cycle |
| `PH_DISP` | `PH_DRAIN` | both discharge regions and the mixing region finished |
| `PH_DRAIN` | `PH_HOLD` | the registered wagon-ready event is seen |
| `PH_HOLD` | `PH_RIGHT` | wagon at left end |
| `PH_RIGHT` | `PH_DUMP` | wagon at right end |
| `PH_DUMP` | `PH_IDLE` | wagon load sensor clears |

The mixing sub-region has the substates `ST_OFF`, `ST_WAIT`, `ST_RUN` and `ST_DONE`.

Top module: `reactor_seq`

## Requirements

Bit map of `sens_i`:

| Bit | Meaning |
|---|---|
| 0 | start |
| 1 | scale 1 full |
| 2 | scale 1 holds material |
| 3 | scale 2 full |
| 4 | scale 2 holds material |
| 5 | mix enable |
| 6 | mix hold |
| 7 | wagon at left end |
| 8 | wagon at right end |
| 9 | wagon loaded |

Bit map of `act_o`:

| Bit | Meaning |
|---|---|
| 0 | pump 1 |
| 1 | pump 2 |
| 2 | scale 1 valve |
| 3 | scale 2 valve |
| 4 | drain |
| 5 | tip |
| 6 | agitator |
| 7 | wagon right |
| 8 | wagon left |

- R1: A synchronous active-high `rst_i` forces `PH_IDLE` and `act_o` to zero at the next edge, whatever phase was active.
- R2: In `PH_IDLE`, `act_o` stays zero until `sens_i[0]` is sampled high. The edge that samples it enters preparation and sets `act_o` bits 0, 1 and 8 (0x103).
- R3: In preparation, pump 1 (bit 0) runs until `sens_i[1]` is high, pump 2 (bit 1) until `sens_i[3]` is high, and wagon-left (bit 8) until `sens_i[7]` is high. Each output drops at the edge that samples its own condition, independently of the others.
- R4: Preparation is left one cycle after its last sub-region finishes. `PH_REACT` then lasts exactly one cycle with `act_o` zero, followed by dispensing.
- R5: Entering dispensing sets bits 2 and 3 (0x00C). Bit 2 drops at the edge sampling `sens_i[2]` low; bit 3 drops at the edge sampling `sens_i[4]` low.
- R6: The mixing region starts in `ST_WAIT` on dispensing entry. From `ST_WAIT` or `ST_RUN`, `sens_i[6]` low moves it to `ST_DONE`, with priority over everything else. Otherwise `sens_i[5]` high selects `ST_RUN` (agitator bit 6 set) and `sens_i[5]` low selects `ST_WAIT`.
- R7: Dispensing is left one cycle after all three of its regions finish. The drain (bit 4) is then on for exactly two cycles, because the wagon-ready event is registered. The block then waits in `PH_HOLD` with `act_o` zero.
- R8: `PH_HOLD` goes to wagon-right (bit 7) on `sens_i[7]` high. Wagon-right lasts until `sens_i[8]` is high, then tipping (bit 5) runs until `sens_i[9]` is low. The block then returns to `PH_IDLE` with `act_o` zero.
- R9: Every preparation and discharge output is on for at least one cycle after its phase is entered, even when its stop condition already holds on entry.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sens_i | input | 10 | Sensor and operator inputs, bit map in the requirements |
| act_o | output | 9 | Actuator commands, bit map in the requirements |

## Verification

A wrong phase or sub-region register shows on `act_o` one cycle later at the latest, because every output bit is decoded straight from registered state.

The exceptions are the silent cycles: the join cycles, `PH_REACT` and `PH_HOLD` all have an all-zero output. A fault that only swaps one silent phase for another surfaces on the edge that should bring the next non-zero pattern. The bench therefore samples every cycle of a batch, including these silent ones. A stray mixing substate shows as bit 6 during dispensing. An error in the length of the drain shows as a count of bit-4 cycles other than two.

// File: rtl/reactor_seq_pkg.sv
package reactor_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_PREP, PH_REACT, PH_DISP,
        PH_DRAIN, PH_HOLD, PH_RIGHT, PH_DUMP
    } phase_e;

    typedef enum logic [1:0] {
        ST_OFF, ST_WAIT, ST_RUN, ST_DONE
    } mix_e;

    // sensor bit positions
    localparam int SN_START      = 0;
    localparam int SN_MIX_EN     = 5;
    localparam int SN_MIX_HOLD   = 6;
    localparam int SN_LEFT_END   = 7;
    localparam int SN_RIGHT_END  = 8;
    localparam int SN_WAGON_FULL = 9;

    // actuator bit positions
    localparam int AC_DRAIN = 4;
    localparam int AC_TIP   = 5;
    localparam int AC_MIX   = 6;
    localparam int AC_RIGHT = 7;

    // run-until leaf regions: fill 1, fill 2, wagon left, discharge 1, discharge 2
    localparam int NLEAF = 5;
    localparam int LEAF_SENS [NLEAF] = '{1, 3, 7, 2, 4};
    localparam int LEAF_ACT  [NLEAF] = '{0, 1, 8, 2, 3};
    localparam logic [NLEAF-1:0] LEAF_STOP_HI = 5'b00111;
    localparam logic [NLEAF-1:0] LEAF_IN_PREP = 5'b00111;
    localparam logic [NLEAF-1:0] LEAF_IN_DISP = ~LEAF_IN_PREP;

endpackage

// File: rtl/reactor_leaf.sv
module reactor_leaf #(
    parameter bit STOP_HI = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic enter_i,
    input  logic stop_i,
    output logic act_o,
    output logic fin_o
);
    logic act_q, fin_q, stop_hit;

    assign stop_hit = STOP_HI ? stop_i : !stop_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q <= 1'b0;
            fin_q <= 1'b0;
        end else if (enter_i) begin
            act_q <= 1'b1;
            fin_q <= 1'b0;
        end else if (act_q && stop_hit) begin
            act_q <= 1'b0;
            fin_q <= 1'b1;
        end
    end

    assign act_o = act_q;
    assign fin_o = fin_q;

    // R3 R5
    leaf_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_q && stop_hit && !enter_i) |=> (!act_q && fin_q));
    // R9
    leaf_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        enter_i |=> (act_q && !fin_q));
endmodule

// File: rtl/reactor_mix.sv
module reactor_mix
    import reactor_seq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic enter_i,
    input  logic en_i,
    input  logic hold_i,
    output logic run_o,
    output logic fin_o
);
    mix_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  st_d = ST_OFF;
            ST_WAIT: if (!hold_i) st_d = ST_DONE; else if (en_i) st_d = ST_RUN;
            ST_RUN:  if (!hold_i) st_d = ST_DONE; else if (!en_i) st_d = ST_WAIT;
            ST_DONE: st_d = ST_DONE;
        endcase
        if (enter_i) st_d = ST_WAIT;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_OFF;
        else       st_q <= st_d;
    end

    assign run_o = (st_q == ST_RUN);
    assign fin_o = (st_q == ST_DONE);

    // R6
    mix_hold_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((st_q == ST_WAIT || st_q == ST_RUN) && !hold_i && !enter_i) |=> fin_o);
    // R6
    mix_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_WAIT && hold_i && en_i && !enter_i) |=> run_o);
endmodule

// File: rtl/reactor_seq.sv
module reactor_seq
    import reactor_seq_pkg::*;
#(
    parameter int N_SENS = 10,
    parameter int N_ACT  = 9
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_SENS-1:0] sens_i,
    output logic [N_ACT-1:0]  act_o
);
    phase_e phase_q, phase_d;
    logic   ready_q;                 // registered wagon-ready event
    logic   prep_enter, disp_enter;
    logic   prep_join, disp_join;
    logic   mix_run, mix_fin;
    logic [NLEAF-1:0] leaf_act, leaf_fin;

    assign prep_enter = (phase_d == PH_PREP) && (phase_q != PH_PREP);
    assign disp_enter = (phase_d == PH_DISP) && (phase_q != PH_DISP);
    assign prep_join  = &(leaf_fin | ~LEAF_IN_PREP);
    assign disp_join  = (&(leaf_fin | ~LEAF_IN_DISP)) && mix_fin;

    for (genvar g = 0; g < NLEAF; g++) begin : g_leaf
        reactor_leaf #(.STOP_HI(LEAF_STOP_HI[g])) u_leaf (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .enter_i (LEAF_IN_PREP[g] ? prep_enter : disp_enter),
            .stop_i  (sens_i[LEAF_SENS[g]]),
            .act_o   (leaf_act[g]),
            .fin_o   (leaf_fin[g])
        );
    end

    reactor_mix u_mix (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .enter_i (disp_enter),
        .en_i    (sens_i[SN_MIX_EN]),
        .hold_i  (sens_i[SN_MIX_HOLD]),
        .run_o   (mix_run),
        .fin_o   (mix_fin)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (sens_i[SN_START])       phase_d = PH_PREP;
            PH_PREP:  if (prep_join)              phase_d = PH_REACT;
            PH_REACT:                             phase_d = PH_DISP;
            PH_DISP:  if (disp_join)              phase_d = PH_DRAIN;
            PH_DRAIN: if (ready_q)                phase_d = PH_HOLD;
            PH_HOLD:  if (sens_i[SN_LEFT_END])    phase_d = PH_RIGHT;
            PH_RIGHT: if (sens_i[SN_RIGHT_END])   phase_d = PH_DUMP;
            PH_DUMP:  if (!sens_i[SN_WAGON_FULL]) phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            ready_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            ready_q <= (phase_q == PH_DRAIN);
        end
    end

    always_comb begin
        act_o = '0;
        for (int g = 0; g < NLEAF; g++) act_o[LEAF_ACT[g]] = leaf_act[g];
        act_o[AC_MIX] = mix_run;
        unique case (phase_q)
            PH_DRAIN: act_o[AC_DRAIN] = 1'b1;
            PH_RIGHT: act_o[AC_RIGHT] = 1'b1;
            PH_DUMP:  act_o[AC_TIP]   = 1'b1;
            default:  ;
        endcase
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_IDLE && !sens_i[SN_START]) |=> (act_o == '0));
    // R4
    react_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_REACT) |=> (phase_q == PH_DISP));
    // R7
    drain_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(act_o[AC_DRAIN]) |=> act_o[AC_DRAIN]);
    // R7
    drain_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_DRAIN && ready_q) |=> (phase_q == PH_HOLD));
    // R8
    right_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_RIGHT && sens_i[SN_RIGHT_END]) |=> act_o[AC_TIP]);
endmodule

// File: tb/reactor_seq_tb_top.sv
module reactor_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 34;

    // sensor pattern applied, actuator pattern expected after the next edge
    localparam logic [9:0] SENS_V [NV] = '{
        10'h000, 10'h001, 10'h000, 10'h002, 10'h00A, 10'h08A, 10'h08A, 10'h054,
        10'h074, 10'h070, 10'h040, 10'h060, 10'h000, 10'h000, 10'h000, 10'h000,
        10'h000, 10'h080, 10'h000, 10'h300, 10'h200, 10'h000, 10'h000, 10'h08B,
        10'h08B, 10'h08B, 10'h000, 10'h000, 10'h000, 10'h000, 10'h080, 10'h080,
        10'h100, 10'h000 };
    localparam logic [8:0] ACT_V [NV] = '{
        9'h000, 9'h103, 9'h103, 9'h102, 9'h100, 9'h000, 9'h000, 9'h00C,
        9'h04C, 9'h048, 9'h000, 9'h040, 9'h000, 9'h010, 9'h010, 9'h000,
        9'h000, 9'h080, 9'h080, 9'h020, 9'h020, 9'h000, 9'h000, 9'h103,
        9'h000, 9'h000, 9'h00C, 9'h000, 9'h010, 9'h010, 9'h000, 9'h080,
        9'h020, 9'h000 };
    // requirement number per vector: R2 idle/start, R3 fills, R4 join/react,
    // R5 discharge, R6 mixing, R7 drain, R8 wagon, R9 minimum one cycle
    localparam int REQ_V [NV] = '{
        2, 2, 3, 3, 3, 3, 4, 4, 6, 5, 5, 6, 6, 7, 7, 7,
        8, 8, 8, 8, 8, 8, 2, 9, 9, 4, 5, 6, 7, 7, 7, 8,
        8, 8 };

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic [9:0] sens_i = '0;
    logic [8:0] act_o;
    int n_run = 0;
    int n_fail = 0;

    reactor_seq dut_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sens_i (sens_i),
        .act_o  (act_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    task automatic check(input string req, input logic [8:0] exp);
        n_run++;
        if (act_o !== exp) begin
            n_fail++;
            $display("FAIL %s: act_o=%h expected %h at %0t", req, act_o, exp, $time);
        end
    endtask

    // called at a falling edge: drive, let one rising edge pass, check
    task automatic step(input logic [9:0] s, input string req, input logic [8:0] exp);
        sens_i = s;
        @(negedge clk_i);
        check(req, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: act_o=%h expected run to finish", act_o);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1", 9'h000);                      // R1 reset state
        rst_i = 1'b0;

        for (int i = 0; i < NV; i++)
            step(SENS_V[i], $sformatf("R%0d vec%0d", REQ_V[i], i), ACT_V[i]);

        // R1: reset in the middle of preparation
        step(10'h001, "R2", 9'h103);
        rst_i = 1'b1;
        step(10'h000, "R1", 9'h000);
        rst_i = 1'b0;
        step(10'h000, "R1", 9'h000);

        // R6: mix hold low beats mix enable high
        step(10'h08B, "R2", 9'h103);
        step(10'h08B, "R3", 9'h000);
        step(10'h08B, "R4", 9'h000);
        step(10'h034, "R5", 9'h00C);
        step(10'h034, "R6", 9'h00C);
        step(10'h020, "R5", 9'h000);
        step(10'h000, "R7", 9'h010);

        rst_i = 1'b1;
        step(10'h000, "R1", 9'h000);
        rst_i = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule